// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses of one SDRAM burst, one per clock. A controller pulses a start strobe together with a start column. The block samples the burst length code and the wrap type on that strobe. From the next clock it drives a column address with a valid flag, and it raises a last flag on the final address of a fixed-length burst.

Fixed-length bursts of 2, 4 or 8 wrap inside the aligned group of columns that holds the start column. The group is walked either in rising order or in the exclusive-or order used for interleaved bursts. A full-page burst walks the whole row upward, rolls over at the top and runs until a terminate input ends it. A new start strobe always replaces the current burst, with no idle clock between the two bursts.

The block issues no bus commands and handles neither data nor rows.

Top module: `sdram_burst_colgen`

## Requirements
- R1: Out of reset and whenever no burst is running, `valid_o` and `last_o` are low and `col_o` is zero.
- R2: With wrap type 0 (sequential) and burst length BL of 2, 4 or 8, address k of the burst keeps the column bits above log2(BL) from the start column. Its low log2(BL) bits equal (start low bits + k) modulo BL.
- R3: With wrap type 1 (interleave) and BL of 2, 4 or 8, address k keeps the upper bits of the start column. Its low log2(BL) bits equal the start low bits XOR k.
- R4: The burst length code `cfg_bl_i` is 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8 and 3'b111=full page. `last_o` is high on exactly the BL-th address. Unless a new start arrives, `valid_o` is low on the clock after it.
- R5: In a full-page burst each address is the previous one plus 1, modulo 2^COL_W. `last_o` stays low, and the burst continues until it is terminated or replaced.
- R6: A start strobe sampled on a clock edge makes the next cycle show `valid_o` high and `col_o` equal to the sampled start column. This holds when a burst is already running, which the strobe aborts, and when `stop_i` is high in the same cycle, because start has priority.
- R7: When `stop_i` is high without `start_i` while a burst is running, the address shown in that cycle is the last one issued, and `valid_o` is low on the next cycle.
- R8: A full-page burst with wrap type 1 uses the sequential order.
- R9: The unused length codes 3'b100, 3'b101 and 3'b110 act as a burst length of 1.
- R10: `cfg_bl_i` and `cfg_wrap_i` are sampled only with a start strobe. Changing them during a burst does not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_bl_i | input | 3 | Burst length code (see R4) |
| cfg_wrap_i | input | 1 | Wrap type: 0 sequential, 1 interleave |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | COL_W | Start column of the new burst |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | `col_o` holds an address of the burst |
| last_o | output | 1 | Final address of a fixed-length burst |

## Verification
The bench builds the block with the default COL_W of 10, which gives a row of 1024 columns. With that width a full-page burst that starts a few columns below 1023 rolls over to column 0 within a handful of clocks. Bursts that start near the top of the row also show that fixed-length wrapping keeps the upper column bits. The abort, back-to-back and start-over-stop cases are each driven on a chosen cycle of a running burst.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

  localparam int unsigned BL_CODE_W = 3;
  // widest fixed burst is 8, so 3 wrap bits
  localparam int unsigned MASK_W    = 3;

  typedef enum logic [BL_CODE_W-1:0] {
    BL_ONE   = 3'b000,
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011,
    BL_PAGE  = 3'b111
  } bl_code_e;

  typedef struct packed {
    logic              full;
    logic              intl;
    logic [MASK_W-1:0] mask;
  } burst_mode_t;

endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import sdram_colgen_pkg::*;
(
  input  logic [BL_CODE_W-1:0] code_i,
  input  logic                 wrap_i,
  output burst_mode_t          mode_o
);

  always_comb begin
    mode_o      = '0;
    mode_o.full = 1'b0;
    unique case (code_i)
      BL_TWO:   mode_o.mask = 3'b001;
      BL_FOUR:  mode_o.mask = 3'b011;
      BL_EIGHT: mode_o.mask = 3'b111;
      BL_PAGE:  mode_o.full = 1'b1;
      default:  mode_o.mask = 3'b000; // length 1, also unused codes
    endcase
    // page bursts only walk upward
    mode_o.intl = wrap_i & ~mode_o.full;
  end

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import sdram_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  burst_mode_t      mode_i,
  output logic             active_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] base_o,
  output burst_mode_t      mode_o,
  output logic             last_o
);

  logic             active_q;
  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] base_q;
  burst_mode_t      mode_q;
  logic             at_end;

  assign at_end = ~mode_q.full && (cnt_q == COL_W'(mode_q.mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
      mode_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      base_q   <= start_col_i;
      mode_q   <= mode_i;
    end else if (active_q) begin
      if (stop_i || at_end) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q    <= cnt_q + COL_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign base_o   = base_q;
  assign mode_o   = mode_q;
  assign last_o   = active_q & at_end;

endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc
  import sdram_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  burst_mode_t      mode_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] xr;

  // low bits of the sum are already modulo BL: carries only move upward
  assign sum = base_i + cnt_i;
  assign xr  = base_i ^ cnt_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    if (b < MASK_W) begin : g_wrap
      assign col_o[b] = mode_i.full    ? sum[b] :
                        !mode_i.mask[b] ? base_i[b] :
                        mode_i.intl    ? xr[b] : sum[b];
    end else begin : g_upper
      assign col_o[b] = mode_i.full ? sum[b] : base_i[b];
    end
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BL_CODE_W-1:0] cfg_bl_i,
  input  logic                 cfg_wrap_i,
  input  logic                 start_i,
  input  logic [COL_W-1:0]     start_col_i,
  input  logic                 stop_i,
  output logic [COL_W-1:0]     col_o,
  output logic                 valid_o,
  output logic                 last_o
);

  burst_mode_t      mode_new;
  burst_mode_t      mode_cur;
  logic             active;
  logic [COL_W-1:0] cnt;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] col_raw;

  burst_mode_dec u_dec (
    .code_i (cfg_bl_i),
    .wrap_i (cfg_wrap_i),
    .mode_o (mode_new)
  );

  burst_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .mode_i      (mode_new),
    .active_o    (active),
    .cnt_o       (cnt),
    .base_o      (base),
    .mode_o      (mode_cur),
    .last_o      (last_o)
  );

  burst_col_calc #(.COL_W(COL_W)) u_calc (
    .base_i (base),
    .cnt_i  (cnt),
    .mode_i (mode_cur),
    .col_o  (col_raw)
  );

  assign valid_o = active;
  assign col_o   = active ? col_raw : '0;

endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       cfg_bl_i,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);

  logic page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      page_q <= 1'b0;
    else if (start_i) page_q <= (cfg_bl_i == 3'b111);
  end

  // R1
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!last_o && col_o == '0));

  // R6
  a_r6_first_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  // R4
  a_r4_end_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && last_o && !start_i) |=> !valid_o);

  // R7
  a_r7_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && stop_i && !start_i) |=> !valid_o);

  // R5
  a_r5_page_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && page_q && !start_i && !stop_i) |=>
      (valid_o && col_o == COL_W'($past(col_o) + COL_W'(1))));

  // R5
  a_r5_page_no_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && page_q) |-> !last_o);

endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_bl_i    (cfg_bl_i),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/sim_sdram_burst_colgen.sv
module sim_sdram_burst_colgen;

  localparam int unsigned COL_W = 10;
  localparam int          ROW   = 1 << COL_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [2:0]       cfg_bl_i = 3'b000;
  logic             cfg_wrap_i = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int total = 0;
  int bad   = 0;

  always #5 clk_i = ~clk_i;

  sdram_burst_colgen #(.COL_W(COL_W)) u0 (
    .clk_i, .rst_ni, .cfg_bl_i, .cfg_wrap_i, .start_i,
    .start_col_i, .stop_i, .col_o, .valid_o, .last_o
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic int blen(logic [2:0] code);
    case (code)
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(int col, logic [2:0] code, logic wrap, int k);
    int l, lo, base;
    if (code == 3'b111) return (col + k) % ROW;
    l    = blen(code);
    lo   = col % l;
    base = col - lo;
    if (wrap) return base + (lo ^ k);
    return base + ((lo + k) % l);
  endfunction

  // drive one burst of n addresses; stop on the n-th if stop_end
  task automatic run_burst(string req, logic [2:0] code, logic wrap,
                           int col, int n, bit stop_end);
    bit page = (code == 3'b111);
    cfg_bl_i = code; cfg_wrap_i = wrap;
    start_col_i = COL_W'(col); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R10: scramble config while the burst runs
    cfg_bl_i = ~code; cfg_wrap_i = ~wrap;
    for (int k = 0; k < n; k++) begin
      check({req, " valid"}, int'(valid_o), 1);
      check({req, " col"}, int'(col_o), exp_col(col, code, page ? 1'b0 : wrap, k));
      check({req, " last"}, int'(last_o), (!page && k == n - 1) ? 1 : 0);
      if (stop_end && k == n - 1) stop_i = 1'b1;
      @(negedge clk_i);
      stop_i = 1'b0;
    end
    check({req, " end valid"}, int'(valid_o), 0);
    check({req, " end last"}, int'(last_o), 0);
  endtask

  task automatic test_reset();
    check("R1 reset valid", int'(valid_o), 0);
    check("R1 reset last", int'(last_o), 0);
    check("R1 reset col", int'(col_o), 0);
  endtask

  task automatic test_sequential();
    run_burst("R2 seq bl8 top", 3'b011, 1'b0, 'h3FD, 8, 1'b0);
    run_burst("R2 seq bl4", 3'b010, 1'b0, 'h1A6, 4, 1'b0);
    run_burst("R2 seq bl2", 3'b001, 1'b0, 'h0FF, 2, 1'b0);
    run_burst("R4 bl1", 3'b000, 1'b0, 'h2C3, 1, 1'b0);
  endtask

  task automatic test_interleave();
    run_burst("R3 intl bl8", 3'b011, 1'b1, 'h15, 8, 1'b0);
    run_burst("R3 intl bl4", 3'b010, 1'b1, 'h3F9, 4, 1'b0);
    run_burst("R3 intl bl2", 3'b001, 1'b1, 'h201, 2, 1'b0);
  endtask

  task automatic test_page();
    run_burst("R5 R7 page wrap", 3'b111, 1'b0, 'h3FC, 9, 1'b1);
    run_burst("R8 page intl", 3'b111, 1'b1, 'h0F5, 7, 1'b1);
    run_burst("R5 page long", 3'b111, 1'b0, 'h000, 40, 1'b1);
  endtask

  task automatic test_reserved();
    run_burst("R9 code100", 3'b100, 1'b1, 'h0A7, 1, 1'b0);
    run_burst("R9 code101", 3'b101, 1'b0, 'h3FF, 1, 1'b0);
    run_burst("R9 code110", 3'b110, 1'b1, 'h155, 1, 1'b0);
  endtask

  task automatic test_abort();
    cfg_bl_i = 3'b011; cfg_wrap_i = 1'b0;
    start_col_i = 'h26; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R6 pre-abort col", int'(col_o), exp_col('h26, 3'b011, 1'b0, k));
      check("R6 pre-abort last", int'(last_o), 0);
      if (k == 2) begin
        cfg_bl_i = 3'b010; cfg_wrap_i = 1'b1;
        start_col_i = 'h105; start_i = 1'b1;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check("R6 abort valid", int'(valid_o), 1);
      check("R6 abort col", int'(col_o), exp_col('h105, 3'b010, 1'b1, k));
      check("R6 abort last", int'(last_o), (k == 3) ? 1 : 0);
      @(negedge clk_i);
    end
    check("R6 abort end", int'(valid_o), 0);
  endtask

  task automatic test_back_to_back();
    // restart on the last address: no gap, and start beats stop
    cfg_bl_i = 3'b001; cfg_wrap_i = 1'b0;
    start_col_i = 'h07; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R2 b2b col0", int'(col_o), 'h06 + 1);
    @(negedge clk_i);
    check("R4 b2b last", int'(last_o), 1);
    check("R2 b2b col1", int'(col_o), 'h06);
    cfg_bl_i = 3'b111; start_col_i = 'h3FF;
    start_i = 1'b1; stop_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; stop_i = 1'b0;
    check("R6 b2b valid", int'(valid_o), 1);
    check("R6 start over stop col", int'(col_o), 'h3FF);
    @(negedge clk_i);
    check("R5 page roll col", int'(col_o), 'h000);
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
    check("R7 stop valid", int'(valid_o), 0);
    check("R1 idle col", int'(col_o), 0);
    // stop while idle has no effect
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
    check("R1 idle stop", int'(valid_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    $display("FAIL R1 watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_reset();
    test_sequential();
    test_interleave();
    test_page();
    test_reserved();
    test_abort();
    test_back_to_back();
    repeat (2) @(negedge clk_i);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule